// File: doc/BRIEF.md
# Precise Exception Acceptance Unit

This unit sits beside a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back). It chooses which exception the machine takes, and it always picks the one that belongs to the oldest instruction in program order. Each instruction carries a small exception tag as it moves down the pipeline. A fetch-side translation miss sets the tag when the instruction is captured. Decode-time faults are merged into the tag while the instruction sits in decode. A data-side translation miss is added when the instruction reaches memory access. An instruction that collected a fault earlier keeps that fault.

The decision is taken only when a tagged instruction occupies the memory-access slot. By then every older instruction has left for write-back, so none of them can still fault. On acceptance the unit empties every slot at once and blocks write-back for the faulting instruction and all younger ones. In the next cycle it raises a one-cycle flush together with a valid exception code. It also registers the faulting instruction's address as the restart point. Fetch then resumes from that address. The faulting instruction runs again, and the younger ones follow and may raise their own faults in turn. A stall input freezes the slots, and decode faults reported during a stall stay attached to their instruction.

Top module: `exc_accept_unit`

## Requirements
- R1: A synchronous reset clears every pending tag and every occupied slot. In the cycle after reset, flush, exc_vld and wb_vld are low and restart_pc is zero. An instruction that was tagged before the reset is never accepted.
- R2: The exception codes are: 1 for a fetch translation miss and 7 for a data translation miss. The decode kinds map from dec_exc bits: bit 0 general illegal gives 2, bit 1 slot illegal gives 3, bit 2 general FPU disable gives 4, bit 3 slot FPU disable gives 5, and bit 4 unconditional trap gives 6. Only codes 1 to 7 appear with exc_vld.
- R3: When several instructions fault, the oldest one in program order is accepted. This holds even when a younger instruction's fault was detected in the same cycle or earlier.
- R4: Within one instruction, a fetch miss outranks any decode fault, and a decode fault outranks a data miss. Among decode bits, the lowest set bit wins.
- R5: An exception is accepted in the cycle its instruction occupies the memory-access slot. exc_vld and flush are asserted in the following cycle.
- R6: flush is a single-cycle pulse, and exc_vld is high exactly in the cycles when flush is high.
- R7: Instructions older than the accepted one leave on wb_vld/wb_pc in program order. The faulting instruction and every younger one never appear on wb_vld.
- R8: restart_pc holds the address of the accepted instruction, and restart_pc and exc_code stay stable until the next acceptance.
- R9: While adv is low, no slot moves, no instruction reaches write-back, and a decode fault reported during the stall stays with its instruction.
- R10: Instructions and fault inputs presented in the acceptance cycle or the flush cycle are discarded. Instructions presented after the flush run normally and can fault in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Pipeline advance; low stalls every slot |
| if_vld | input | 1 | Fetch stage holds an instruction |
| if_pc | input | PCW | Address of the fetched instruction |
| if_itlb_miss | input | 1 | Fetch translation miss for that instruction |
| dec_exc | input | 5 | Decode fault kinds for the instruction in decode |
| ma_dtlb_miss | input | 1 | Data translation miss for the instruction in memory access |
| flush | output | 1 | One-cycle cancel of the faulting and younger instructions |
| exc_vld | output | 1 | Accepted exception valid |
| exc_code | output | 4 | Accepted exception code |
| restart_pc | output | PCW | Address to restart from |
| wb_vld | output | 1 | Instruction committed to write-back this cycle |
| wb_pc | output | PCW | Address of the committed instruction |

## Verification
The bound assertions check the following on every cycle: the reset state, the legal code range, acceptance only after a tagged memory-access slot, the single-cycle flush with write-back silenced around it, hold of the restart address and code between acceptances, and the freeze of the decode slot during a stall. Program-order selection among several faulting instructions, the priority inside one instruction, the exact commit sequence, the discarding of flush-cycle inputs and re-execution after restart depend on whole instruction streams. Only the bench scenarios show them, by comparing committed addresses and accepted exceptions against an independently computed expected list.

// File: rtl/exc_accept_pkg.sv
package exc_accept_pkg;
  localparam int CODE_W    = 4;
  localparam int DEC_KINDS = 5;

  typedef logic [CODE_W-1:0] exc_code_t;

  localparam exc_code_t EXC_NONE    = 4'd0;
  localparam exc_code_t EXC_ITLB    = 4'd1;
  localparam exc_code_t EXC_DEC_LOW = 4'd2;  // first decode kind, others follow
  localparam exc_code_t EXC_DTLB    = 4'd7;

  // Decode kinds share one rank; the lowest set bit is taken.
  function automatic exc_code_t decode_kind(input logic [DEC_KINDS-1:0] kinds);
    exc_code_t c;
    c = EXC_NONE;
    for (int i = DEC_KINDS - 1; i >= 0; i--) begin
      if (kinds[i]) c = exc_code_t'(int'(EXC_DEC_LOW) + i);
    end
    return c;
  endfunction

  // An earlier fault of the same instruction is kept.
  function automatic exc_code_t keep_first(input exc_code_t held, input exc_code_t fresh);
    return (held != EXC_NONE) ? held : fresh;
  endfunction
endpackage

// File: rtl/exc_slot_pipe.sv
module exc_slot_pipe
  import exc_accept_pkg::*;
#(
  parameter int PCW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 flush,
  input  logic                 if_vld,
  input  logic [PCW-1:0]       if_pc,
  input  logic                 if_itlb_miss,
  input  logic [DEC_KINDS-1:0] dec_exc,
  input  logic                 ma_dtlb_miss,
  output logic                 ma_hit,
  output exc_code_t            ma_code,
  output logic [PCW-1:0]       ma_pc,
  output logic                 id_vld,
  output logic [PCW-1:0]       id_pc,
  output logic                 wb_vld,
  output logic [PCW-1:0]       wb_pc
);
  localparam int NSLOT = 3;          // decode, execute, memory access
  localparam int S_ID  = 0;
  localparam int S_MA  = NSLOT - 1;

  typedef struct packed {
    logic           vld;
    logic [PCW-1:0] pc;
    exc_code_t      code;
  } slot_t;

  slot_t slot [NSLOT];
  slot_t slot_eff [NSLOT];
  slot_t fetch_in;
  slot_t wb_q;

  always_comb begin
    fetch_in.vld  = if_vld;
    fetch_in.pc   = if_pc;
    fetch_in.code = (if_vld && if_itlb_miss) ? EXC_ITLB : EXC_NONE;
  end

  // Per-slot tag with the faults detected in that slot merged in.
  for (genvar s = 0; s < NSLOT; s++) begin : g_eff
    always_comb begin
      slot_eff[s] = slot[s];
      if (!slot[s].vld) begin
        slot_eff[s].code = EXC_NONE;
      end else if (s == S_ID) begin
        slot_eff[s].code = keep_first(slot[s].code, decode_kind(dec_exc));
      end else if (s == S_MA) begin
        slot_eff[s].code = keep_first(slot[s].code, ma_dtlb_miss ? EXC_DTLB : EXC_NONE);
      end
    end
  end

  assign ma_hit  = slot_eff[S_MA].code != EXC_NONE;
  assign ma_code = slot_eff[S_MA].code;
  assign ma_pc   = slot[S_MA].pc;
  assign id_vld  = slot[S_ID].vld;
  assign id_pc   = slot[S_ID].pc;
  assign wb_vld  = wb_q.vld;
  assign wb_pc   = wb_q.pc;

  always_ff @(posedge clk) begin
    if (rst || ma_hit || flush) begin
      for (int s = 0; s < NSLOT; s++) slot[s] <= '0;
      wb_q <= '0;
    end else if (adv) begin
      slot[S_ID] <= fetch_in;
      for (int s = 1; s < NSLOT; s++) slot[s] <= slot_eff[s-1];
      wb_q <= slot[S_MA];
    end else begin
      slot[S_ID].code <= slot_eff[S_ID].code;
      wb_q.vld        <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_accept_pkg::*;
#(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ma_hit,
  input  exc_code_t      ma_code,
  input  logic [PCW-1:0] ma_pc,
  output logic           flush,
  output logic           exc_vld,
  output exc_code_t      exc_code,
  output logic [PCW-1:0] restart_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flush      <= 1'b0;
      exc_vld    <= 1'b0;
      exc_code   <= EXC_NONE;
      restart_pc <= '0;
    end else begin
      flush   <= ma_hit;
      exc_vld <= ma_hit;
      if (ma_hit) begin
        exc_code   <= ma_code;
        restart_pc <= ma_pc;
      end
    end
  end
endmodule

// File: rtl/exc_accept_unit.sv
module exc_accept_unit
  import exc_accept_pkg::*;
#(
  parameter int PCW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic                 if_vld,
  input  logic [PCW-1:0]       if_pc,
  input  logic                 if_itlb_miss,
  input  logic [DEC_KINDS-1:0] dec_exc,
  input  logic                 ma_dtlb_miss,
  output logic                 flush,
  output logic                 exc_vld,
  output logic [CODE_W-1:0]    exc_code,
  output logic [PCW-1:0]       restart_pc,
  output logic                 wb_vld,
  output logic [PCW-1:0]       wb_pc
);
  logic           ma_hit;
  exc_code_t      ma_code;
  logic [PCW-1:0] ma_pc;
  logic           id_vld;
  logic [PCW-1:0] id_pc;

  exc_slot_pipe #(.PCW(PCW)) u_pipe (
    .clk(clk), .rst(rst), .adv(adv), .flush(flush),
    .if_vld(if_vld), .if_pc(if_pc), .if_itlb_miss(if_itlb_miss),
    .dec_exc(dec_exc), .ma_dtlb_miss(ma_dtlb_miss),
    .ma_hit(ma_hit), .ma_code(ma_code), .ma_pc(ma_pc),
    .id_vld(id_vld), .id_pc(id_pc),
    .wb_vld(wb_vld), .wb_pc(wb_pc)
  );

  exc_capture #(.PCW(PCW)) u_cap (
    .clk(clk), .rst(rst),
    .ma_hit(ma_hit), .ma_code(ma_code), .ma_pc(ma_pc),
    .flush(flush), .exc_vld(exc_vld), .exc_code(exc_code),
    .restart_pc(restart_pc)
  );
endmodule

// File: rtl/exc_accept_chk.sv
module exc_accept_chk #(
  parameter int PCW = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           adv,
  input logic           flush,
  input logic           exc_vld,
  input logic [3:0]     exc_code,
  input logic [PCW-1:0] restart_pc,
  input logic           wb_vld,
  input logic           ma_hit,
  input logic           id_vld,
  input logic [PCW-1:0] id_pc
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flush && !exc_vld && !wb_vld && restart_pc == '0));

  assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
    exc_vld |-> (exc_code >= 4'd1 && exc_code <= 4'd7));

  assert_accept_from_ma_R5: assert property (@(posedge clk) disable iff (rst)
    exc_vld |-> $past(ma_hit));

  assert_ma_hit_taken_R5: assert property (@(posedge clk) disable iff (rst)
    ma_hit |=> exc_vld);

  assert_flush_single_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  assert_no_wb_at_flush_R7: assert property (@(posedge clk) disable iff (rst)
    flush |-> !wb_vld);

  assert_no_wb_after_flush_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !wb_vld);

  assert_restart_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!exc_vld && !$past(rst)) |-> ($stable(restart_pc) && $stable(exc_code)));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (id_vld && !adv && !ma_hit && !flush) |=> (id_vld && $stable(id_pc)));
endmodule

bind exc_accept_unit exc_accept_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .adv(adv), .flush(flush), .exc_vld(exc_vld),
  .exc_code(exc_code), .restart_pc(restart_pc), .wb_vld(wb_vld),
  .ma_hit(ma_hit), .id_vld(id_vld), .id_pc(id_pc)
);

// File: tb/exc_accept_unit_tb.sv
module exc_accept_unit_tb;
  localparam int PCW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b1;
  logic if_vld = 1'b0;
  logic [PCW-1:0] if_pc = '0;
  logic if_itlb_miss = 1'b0;
  logic [4:0] dec_exc = '0;
  logic ma_dtlb_miss = 1'b0;
  logic flush, exc_vld, wb_vld;
  logic [3:0] exc_code;
  logic [PCW-1:0] restart_pc, wb_pc;

  always #10 clk = ~clk;  // 50 MHz

  exc_accept_unit #(.PCW(PCW)) u_dut (
    .clk(clk), .rst(rst), .adv(adv), .if_vld(if_vld), .if_pc(if_pc),
    .if_itlb_miss(if_itlb_miss), .dec_exc(dec_exc), .ma_dtlb_miss(ma_dtlb_miss),
    .flush(flush), .exc_vld(exc_vld), .exc_code(exc_code),
    .restart_pc(restart_pc), .wb_vld(wb_vld), .wb_pc(wb_pc)
  );

  typedef struct {
    logic [3:0]     code;
    logic [PCW-1:0] pc;
    string          tag;
  } exp_t;

  exp_t q_exc[$];
  exp_t q_wb[$];
  int n_chk = 0;
  int n_fail = 0;
  string cur_tag = "R1";

  logic       fm [8];
  logic [4:0] dc [8];
  logic       dm [8];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare produced results against the scoreboard queues.
  always @(negedge clk) begin
    if (!rst) begin
      if (exc_vld) begin
        if (q_exc.size() == 0) begin
          check(1'b0, cur_tag, "unexpected exception pc", restart_pc, 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = q_exc.pop_front();
          check(exc_code == e.code, e.tag, "exception code", {28'd0, exc_code}, {28'd0, e.code});
          check(restart_pc == e.pc, e.tag, "restart pc", restart_pc, e.pc);
          check(flush == 1'b1, "R6", "flush with exception", {31'd0, flush}, 32'd1);
        end
      end
      if (wb_vld) begin
        if (q_wb.size() == 0) begin
          check(1'b0, "R7", "unexpected write-back pc", wb_pc, 32'hFFFF_FFFF);
        end else begin
          exp_t w;
          w = q_wb.pop_front();
          check(wb_pc == w.pc, w.tag, "write-back pc", wb_pc, w.pc);
        end
      end
    end
  end

  task automatic clear_faults();
    for (int i = 0; i < 8; i++) begin
      fm[i] = 1'b0; dc[i] = '0; dm[i] = 1'b0;
    end
  endtask

  function automatic logic [3:0] expect_code(input int i);
    if (fm[i]) return 4'd1;
    for (int b = 0; b < 5; b++) if (dc[i][b]) return 4'(2 + b);
    if (dm[i]) return 4'd7;
    return 4'd0;
  endfunction

  // Driver: push expectations, then drive the stream slot by slot.
  task automatic run(input logic [PCW-1:0] base, input int n,
                     input logic [63:0] stall, input string tag);
    int first = -1;
    int lim;
    int nxt = 0, id = -1, ex = -1, ma = -1, cyc = 0;
    bit fin = 0;
    logic [3:0] ecode = 4'd0;
    cur_tag = tag;
    for (int i = 0; i < n; i++) if (first < 0 && expect_code(i) != 4'd0) first = i;
    lim = (first < 0) ? n : first;
    for (int i = 0; i < lim; i++) q_wb.push_back('{4'd0, base + PCW'(2 * i), tag});
    if (first >= 0) begin
      ecode = expect_code(first);
      q_exc.push_back('{ecode, base + PCW'(2 * first), tag});
    end
    while (!fin && cyc < 80) begin
      @(negedge clk);
      if (flush) begin
        // flush cycle: everything offered now must be dropped (R10)
        adv = 1'b1; if_vld = 1'b1; if_pc = 32'h0000_BAD0;
        if_itlb_miss = 1'b1; dec_exc = '1; ma_dtlb_miss = 1'b1;
        @(negedge clk);
        fin = 1;
      end else begin
        adv = !stall[cyc % 64];
        if_vld = (nxt < n);
        if_pc = base + PCW'(2 * nxt);
        if_itlb_miss = (nxt < n) ? fm[nxt] : 1'b0;
        dec_exc = (id >= 0) ? dc[id] : 5'd0;
        ma_dtlb_miss = (ma >= 0) ? dm[ma] : 1'b0;
        @(posedge clk);
        if (adv) begin
          ma = ex; ex = id;
          if (nxt < n) begin id = nxt; nxt++; end else id = -1;
        end
        cyc++;
        if (nxt == n && id < 0 && ex < 0 && ma < 0) fin = 1;
      end
    end
    adv = 1'b1; if_vld = 1'b0; if_itlb_miss = 1'b0; dec_exc = '0; ma_dtlb_miss = 1'b0;
    repeat (8) @(negedge clk);
    check(q_exc.size() == 0, tag, "pending expected exceptions", q_exc.size(), 0);
    check(q_wb.size() == 0, tag, "pending expected write-backs", q_wb.size(), 0);
    if (first >= 0) begin
      check(restart_pc == base + PCW'(2 * first), "R8", "restart pc held", restart_pc,
            base + PCW'(2 * first));
      check(exc_code == ecode, "R8", "code held", {28'd0, exc_code}, {28'd0, ecode});
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!flush && !exc_vld && !wb_vld, "R1", "flags after reset",
          {29'd0, flush, exc_vld, wb_vld}, 0);
    check(restart_pc == '0, "R1", "restart pc after reset", restart_pc, 0);

    // R7: clean stream commits in order
    clear_faults();
    run(32'h100, 6, 64'd0, "R7");

    // R5 / R2: data miss accepted in memory access
    clear_faults(); dm[2] = 1'b1;
    run(32'h200, 5, 64'd0, "R5");

    // R3: same-cycle decode fault on n+1 and fetch miss on n+2
    clear_faults(); dc[1] = 5'b00001; fm[2] = 1'b1;
    run(32'h300, 5, 64'd0, "R3");
    // R10: restart from n+1, its younger fetch miss is then taken
    clear_faults(); fm[1] = 1'b1;
    run(32'h302, 4, 64'd0, "R10");

    // R3: younger fetch miss detected before older data miss
    clear_faults(); dm[0] = 1'b1; fm[2] = 1'b1;
    run(32'h400, 4, 64'd0, "R3");

    // R4: priorities inside one instruction
    clear_faults(); fm[1] = 1'b1; dc[1] = 5'b10000; dm[1] = 1'b1;
    run(32'h500, 4, 64'd0, "R4");
    clear_faults(); dc[0] = 5'b11000;
    run(32'h520, 3, 64'd0, "R4");
    clear_faults(); dc[2] = 5'b00100; dm[2] = 1'b1;
    run(32'h540, 4, 64'd0, "R4");

    // R2: each decode kind alone
    for (int b = 0; b < 5; b++) begin
      clear_faults(); dc[1][b] = 1'b1;
      run(32'h600 + 32'(b * 16), 3, 64'd0, "R2");
    end

    // R9: stalls while a decode fault sits in decode, and a clean stalled stream
    clear_faults(); dc[1] = 5'b10000;
    run(32'h700, 4, 64'b0001_1100, "R9");
    clear_faults();
    run(32'h740, 5, 64'b0110_0110_0100, "R9");

    // R1: reset while a tagged instruction is in flight
    cur_tag = "R1";
    @(negedge clk);
    if_vld = 1'b1; if_pc = 32'h800;
    @(negedge clk);
    if_vld = 1'b0; dec_exc = 5'b00001;
    @(negedge clk);
    dec_exc = '0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);
    check(restart_pc == '0, "R1", "restart pc cleared by reset", restart_pc, 0);
    check(!exc_vld && !flush, "R1", "no acceptance after reset",
          {30'd0, exc_vld, flush}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule